// File: doc/BRIEF.md
# Clear-on-read interrupt status register

This block collects eight single-cycle event pulses from a line-interface or HDLC datapath into an 8-bit sticky status word. A companion 8-bit mask word selects which latched bits may reach the processor's interrupt line. A processor read returns the status word, and the same read clears every bit. An event that arrives in the same cycle as that read is kept, so no event is lost.

The block drives two outputs towards the interrupt system. The first is a combinational, active-high interrupt level. The second is a registered summary bit, meant for a chip-wide interrupt-source word. A visibility control sets the handling of masked events. With visibility on, a masked event is still recorded and can be read, but it never drives either output. With visibility off, a masked event is dropped.

Two events are qualified by the operating mode. The all-sent event counts only in HDLC mode. The signaling-register-empty event counts only while serial signaling access on the system highway is off. A transmit underrun starts a transmitter lockout. The lockout holds the transmitter and its FIFO disabled until software reads the status word.

Top module: `irq_status_reg`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rd_data` is 0x00, `mask_o` is 0xFF, and `irq_o`, `summary_o` and `tx_lock_o` are 0.
- R2: Bit layout: bit 7 = signaling-register-empty, bit 6 = receive overflow, bit 5 = all-sent, bit 4 = transmit underrun, bits 3..1 = further transmit/line events, bit 0 = transmit-pool-ready. An accepted pulse on `evt_i[n]` sets status bit n from the next cycle onward, and the bit stays set until a read.
- R3: `rd_data` always shows the current status word. A cycle with `rd_en` high clears all eight bits from the next cycle.
- R4: A bit accepted in the same cycle as `rd_en` is set after that read.
- R5: With `visible_i` high, an event whose mask bit is 1 is still latched.
- R6: With `visible_i` low, an event whose mask bit is 1 is discarded.
- R7: `irq_o` is 1 exactly when some status bit is 1 and its mask bit is 0. Bits latched while masked never raise it.
- R8: `summary_o` equals the value `irq_o` had one cycle earlier.
- R9: `evt_i[5]` (all-sent) is accepted only when `hdlc_mode_i` is 1.
- R10: `evt_i[7]` (signaling-register-empty) is accepted only when `sig_serial_en_i` is 0.
- R11: An `evt_i[4]` pulse raises `tx_lock_o` from the next cycle, whatever the mask and visibility settings. `tx_lock_o` stays high until a cycle with `rd_en` high and no new `evt_i[4]`, and falls in the cycle after it.
- R12: When `mask_wr_en` is high, `mask_o` takes `mask_wr_data` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Event pulses, one per status bit |
| visible_i | input | 1 | Record masked events when high |
| hdlc_mode_i | input | 1 | HDLC mode selected |
| sig_serial_en_i | input | 1 | Serial signaling access on the highway enabled |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | 8 | Mask write value (1 = masked) |
| mask_o | output | 8 | Current mask word |
| rd_en | input | 1 | Status read strobe (clears status) |
| rd_data | output | 8 | Current status word |
| irq_o | output | 1 | Active-high interrupt level |
| summary_o | output | 1 | Registered summary bit |
| tx_lock_o | output | 1 | Transmitter and transmit-FIFO disable |

## Verification
The bench sends an event and a clearing read in the same cycle. A design that lets the clear win would lose that event, and the bit would read back as zero. It tests masked events with visibility on and with visibility off. Here an error shows up in one of two ways: a masked bit raises `irq_o`, or a bit is latched or dropped wrongly. It sends underruns that are masked, that coincide with a read, and that are followed by long gaps without a read. These tests catch a lockout that ends early or depends on the mask. They also check that the summary bit runs exactly one cycle behind the interrupt level, and that the two mode-qualified events are gated.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int STAT_W      = 8;
  localparam int BIT_SIGEMPT = 7;
  localparam int BIT_RXOVF   = 6;
  localparam int BIT_ALLSENT = 5;
  localparam int BIT_TXUNDR  = 4;
  localparam int BIT_TXREADY = 0;

  // Events that survive the mode qualifiers
  function automatic logic [STAT_W-1:0] mode_qualify(
      input logic [STAT_W-1:0] evt, input logic hdlc, input logic sig_serial);
    logic [STAT_W-1:0] q;
    q = evt;
    q[BIT_ALLSENT] = evt[BIT_ALLSENT] & hdlc;
    q[BIT_SIGEMPT] = evt[BIT_SIGEMPT] & ~sig_serial;
    return q;
  endfunction

  // Masking policy: masked events only pass when visibility is on
  function automatic logic [STAT_W-1:0] mask_filter(
      input logic [STAT_W-1:0] evt, input logic [STAT_W-1:0] mask, input logic vis);
    return vis ? evt : (evt & ~mask);
  endfunction

  function automatic logic any_unmasked(
      input logic [STAT_W-1:0] stat, input logic [STAT_W-1:0] mask);
    return |(stat & ~mask);
  endfunction
endpackage

// File: rtl/irq_evt_gate.sv
module irq_evt_gate
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              visible_i,
  input  logic              hdlc_mode_i,
  input  logic              sig_serial_en_i,
  output logic [STAT_W-1:0] accept_o
);
  logic [STAT_W-1:0] qualified;

  always_comb begin
    qualified = mode_qualify(evt_i, hdlc_mode_i, sig_serial_en_i);
    accept_o  = mask_filter(qualified, mask_i, visible_i);
  end

  assert_allsent_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !hdlc_mode_i |-> !accept_o[BIT_ALLSENT]);
  assert_sigempty_gate_R10: assert property (@(posedge clk) disable iff (rst)
    sig_serial_en_i |-> !accept_o[BIT_SIGEMPT]);
  assert_masked_drop_R6: assert property (@(posedge clk) disable iff (rst)
    !visible_i |-> ((accept_o & mask_i) == '0));
endmodule

// File: rtl/irq_stat_bit.sv
module irq_stat_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (q_o && !clr_i) |=> q_o);
  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/irq_tx_lockout.sv
module irq_tx_lockout (
  input  logic clk,
  input  logic rst,
  input  logic underrun_i,
  input  logic rd_i,
  output logic lock_o
);
  always_ff @(posedge clk) begin
    if (rst)             lock_o <= 1'b0;
    else if (underrun_i) lock_o <= 1'b1;
    else if (rd_i)       lock_o <= 1'b0;
  end

  assert_lock_set_R11: assert property (@(posedge clk) disable iff (rst)
    underrun_i |=> lock_o);
  assert_lock_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (lock_o && !rd_i) |=> lock_o);
  assert_lock_release_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !underrun_i) |=> !lock_o);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              visible_i,
  input  logic              hdlc_mode_i,
  input  logic              sig_serial_en_i,
  input  logic              mask_wr_en,
  input  logic [STAT_W-1:0] mask_wr_data,
  output logic [STAT_W-1:0] mask_o,
  input  logic              rd_en,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq_o,
  output logic              summary_o,
  output logic              tx_lock_o
);
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] accepted;
  logic [STAT_W-1:0] status_q;
  logic              summary_q;
  logic              past_ok_q;

  always_ff @(posedge clk) begin
    if (rst)             mask_q <= '1;
    else if (mask_wr_en) mask_q <= mask_wr_data;
  end

  irq_evt_gate u_gate (
    .clk(clk), .rst(rst), .evt_i(evt_i), .mask_i(mask_q),
    .visible_i(visible_i), .hdlc_mode_i(hdlc_mode_i),
    .sig_serial_en_i(sig_serial_en_i), .accept_o(accepted)
  );

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    irq_stat_bit u_bit (
      .clk(clk), .rst(rst), .set_i(accepted[i]), .clr_i(rd_en), .q_o(status_q[i])
    );
  end

  irq_tx_lockout u_lock (
    .clk(clk), .rst(rst), .underrun_i(evt_i[BIT_TXUNDR]), .rd_i(rd_en), .lock_o(tx_lock_o)
  );

  always_comb irq_o = any_unmasked(status_q, mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      summary_q <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      summary_q <= irq_o;
      past_ok_q <= 1'b1;
    end
  end

  assign rd_data   = status_q;
  assign mask_o    = mask_q;
  assign summary_o = summary_q;

  assert_summary_lag_R8: assert property (@(posedge clk) disable iff (rst)
    past_ok_q |-> (summary_o == $past(irq_o)));
  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ((rd_data & ~mask_o) == '0) |-> !irq_o);
  assert_visible_latch_R5: assert property (@(posedge clk) disable iff (rst)
    (visible_i && evt_i[BIT_RXOVF]) |=> rd_data[BIT_RXOVF]);
  assert_mask_write_R12: assert property (@(posedge clk) disable iff (rst)
    mask_wr_en |=> (mask_o == $past(mask_wr_data)));
endmodule

// File: tb/irq_status_reg_tb.sv
module irq_status_reg_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] evt;
  logic       vis, hdlc, sig;
  logic       mwe;
  logic [7:0] mwd;
  logic [7:0] mask_o;
  logic       rd;
  logic [7:0] rd_data;
  logic       irq_o, summary_o, tx_lock_o;

  int errors = 0;
  int checks = 0;

  logic [7:0] m_stat, m_mask;
  logic       m_lock, m_summ;

  always #4 clk = ~clk;

  irq_status_reg u_dut (
    .clk(clk), .rst(rst), .evt_i(evt), .visible_i(vis), .hdlc_mode_i(hdlc),
    .sig_serial_en_i(sig), .mask_wr_en(mwe), .mask_wr_data(mwd), .mask_o(mask_o),
    .rd_en(rd), .rd_data(rd_data), .irq_o(irq_o), .summary_o(summary_o),
    .tx_lock_o(tx_lock_o)
  );

  function automatic logic [7:0] exp_accept(logic [7:0] e, logic [7:0] m,
                                            logic v, logic h, logic s);
    logic [7:0] a;
    a = e;
    if (!h) a[5] = 1'b0;
    if (s)  a[7] = 1'b0;
    for (int i = 0; i < 8; i++) if (m[i] && !v) a[i] = 1'b0;
    return a;
  endfunction

  function automatic logic exp_irq(logic [7:0] st, logic [7:0] m);
    logic r;
    r = 1'b0;
    for (int i = 0; i < 8; i++) if (st[i] && !m[i]) r = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    evt = '0; rd = 1'b0; mwe = 1'b0; mwd = '0;
  endtask

  // Compare outputs with the model, then advance both one clock
  task automatic step();
    logic [7:0] acc;
    #1;
    chk("R2/R3 rd_data", rd_data, m_stat);
    chk("R7 irq_o", {7'b0, irq_o}, {7'b0, exp_irq(m_stat, m_mask)});
    chk("R8 summary_o", {7'b0, summary_o}, {7'b0, m_summ});
    chk("R11 tx_lock_o", {7'b0, tx_lock_o}, {7'b0, m_lock});
    chk("R12 mask_o", mask_o, m_mask);
    acc = exp_accept(evt, m_mask, vis, hdlc, sig);
    @(posedge clk);
    m_summ = exp_irq(m_stat, m_mask);
    m_stat = (rd ? 8'h00 : m_stat) | acc;
    m_lock = evt[4] ? 1'b1 : (rd ? 1'b0 : m_lock);
    if (mwe) m_mask = mwd;
    @(negedge clk);
    idle();
  endtask

  task automatic set_mask(logic [7:0] v);
    mwe = 1'b1; mwd = v; step();
  endtask

  task automatic do_read();
    rd = 1'b1; step();
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(); vis = 1'b0; hdlc = 1'b1; sig = 1'b0;
    rst = 1'b1;
    m_stat = '0; m_mask = 8'hFF; m_lock = 1'b0; m_summ = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held
    #1;
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 mask_o", mask_o, 8'hFF);
    chk("R1 irq/summary/lock", {5'b0, irq_o, summary_o, tx_lock_o}, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    step();

    // R6: masked event with visibility off is dropped
    evt = 8'h40; step();
    chk("R6 masked dropped", rd_data, 8'h00);
    // R5/R7: visibility on, masked event latched, no irq
    vis = 1'b1; evt = 8'h42; step();
    chk("R5 masked latched", rd_data, 8'h42);
    chk("R7 masked no irq", {7'b0, irq_o}, 8'h00);
    step();
    // R12 unmask bit 6, then irq rises and summary follows (R8)
    set_mask(8'hBF); step(); step();
    chk("R7 unmasked irq", {7'b0, irq_o}, 8'h01);
    chk("R8 summary follows", {7'b0, summary_o}, 8'h01);
    // R3 read clears; R4 coincident event survives
    rd = 1'b1; evt = 8'h01; step();
    chk("R4 coincident kept", rd_data, 8'h01);
    do_read();
    chk("R3 cleared", rd_data, 8'h00);
    // R9 all-sent gated by HDLC mode
    hdlc = 1'b0; evt = 8'h20; step();
    chk("R9 all-sent ignored", rd_data, 8'h00);
    hdlc = 1'b1; evt = 8'h20; step();
    chk("R9 all-sent taken", rd_data, 8'h20);
    // R10 signaling-empty gated by serial access
    sig = 1'b1; evt = 8'h80; step();
    chk("R10 sig-empty ignored", rd_data, 8'h20);
    sig = 1'b0; evt = 8'h80; step();
    chk("R10 sig-empty taken", rd_data, 8'hA0);
    do_read();
    // R11 underrun while masked and invisible still locks, holds without read
    vis = 1'b0; set_mask(8'hFF);
    evt = 8'h10; step();
    chk("R11 lock set", {7'b0, tx_lock_o}, 8'h01);
    chk("R6 masked underrun dropped", rd_data, 8'h00);
    repeat (20) step();
    chk("R11 lock held", {7'b0, tx_lock_o}, 8'h01);
    rd = 1'b1; evt = 8'h10; step();
    chk("R11 lock kept on coincident", {7'b0, tx_lock_o}, 8'h01);
    do_read();
    chk("R11 lock released", {7'b0, tx_lock_o}, 8'h00);

    // Random phase: sparse events, occasional reads and mask writes
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] e;
      e = '0;
      for (int b = 0; b < 8; b++) if ($urandom % 12 == 0) e[b] = 1'b1;
      evt  = e;
      rd   = ($urandom % 9 == 0);
      mwe  = ($urandom % 25 == 0);
      mwd  = 8'($urandom);
      if ($urandom % 50 == 0) vis  = ~vis;
      if ($urandom % 60 == 0) hdlc = ~hdlc;
      if ($urandom % 60 == 0) sig  = ~sig;
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule